// File: doc/BRIEF.md
# MDIO Management Interface Master

This block drives the two-wire serial management bus used to reach the registers of Ethernet PHYs. A host starts one transaction with a single-cycle request carrying the direction (read or write), a 5-bit PHY address, a 5-bit register address and, for a write, a 16-bit value. The block then generates the management clock and shifts the whole frame onto the data line. The bidirectional data line is modelled as three signals: a data output, an output enable and a data input.

The management clock is derived from the system clock. Each low phase and each high phase lasts `HALF_CYCLES` system cycles. The line changes only while the clock is low. The clock rests high between transactions.

For a read, the block releases the line at the turnaround slot and checks that the PHY pulls it low. It then collects 16 data bits. If the turnaround is not answered, the block clocks a run of released idle cycles so that the PHY's state machine can resynchronize, and it reports an error with zeroed data. A one-cycle done pulse ends every transaction. `busy_o` covers the whole frame, and requests made while busy are dropped.

Top module: `mdio_master`

## Requirements
- R1: After reset, and whenever the block is idle, `mdc_o` is 1, `mdio_oe_o` is 0, and `busy_o` and `done_o` are 0.
- R2: A `start_i` pulse while idle raises `busy_o` for the whole frame. The frame ends with `done_o` high for exactly one cycle, in the first cycle that `busy_o` is low again.
- R3: A `start_i` pulse while `busy_o` is high is ignored. The running frame completes unchanged, exactly one done pulse follows, and the block stays idle afterwards.
- R4: Every frame opens with 32 clock cycles (slots 0 to 31) with the line driven to 1, followed by the start pattern 0 (slot 32) then 1 (slot 33).
- R5: The opcode occupies slots 34 and 35 and is 1,0 for a read (`rd_i`=1) and 0,1 for a write (`rd_i`=0).
- R6: The PHY address fills slots 36 to 40 and the register address fills slots 41 to 45, each sent MSB first.
- R7: Every low phase and every high phase of `mdc_o` lasts `HALF_CYCLES` system cycles. `mdio_o` and `mdio_oe_o` never change while `mdc_o` is high within a frame.
- R8: A write drives 1,0 in slots 46 and 47 and the data MSB first in slots 48 to 63. It then releases the line for slot 64, so the frame has 65 clock cycles.
- R9: A read releases the line from slot 46 onward. It samples `mdio_i` (through a two-flop synchronizer) at the end of each high phase. Slot 46 must read 0, and slots 47 to 62 give the data MSB first. Slot 63 is a trailing released cycle, so the frame has 64 clock cycles. `rdata_o` holds the data with `err_o`=0.
- R10: If a read samples 1 at slot 46, the block clocks 32 further released cycles (79 in total) and finishes with `err_o`=1 and `rdata_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle transaction request |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write value |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last read got no turnaround response |
| rdata_o | output | 16 | Last read value (0 after an error) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
The bench captures every slot of every frame on the rising clock edge and sets it against the frame expected from the request. It also measures each clock phase. The bench goes after the missing-turnaround case. A design that skips the recovery run would finish after 64 cycles, and one that leaks the partly shifted data would report nonzero `rdata_o`. It fires a second request in mid-frame. A design that accepted it would restart the preamble or leave a queued frame running after done. Reads with alternating and edge data patterns catch an off-by-one sampling slot, which shows up as data shifted by one bit. Write frames catch a turnaround polarity swap and a missing final released cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   typedef enum logic [1:0] {
      OPC_WRITE = 2'b01,
      OPC_READ  = 2'b10
   } mdio_opc_e;

   localparam logic [1:0] START_PAT = 2'b01;
   localparam logic [1:0] WR_TURN   = 2'b10;
endpackage

// File: rtl/mdio_halfgen.sv
module mdio_halfgen #(
   parameter int HALF_CYCLES = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   output logic tick
);
   localparam int CW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(HALF_CYCLES - 1);

   logic [CW-1:0] cnt_q;

   assign tick = en && (cnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (clr)  cnt_q <= '0;
      else if (tick) cnt_q <= '0;
      else if (en)   cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/mdio_insync.sv
module mdio_insync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("mdio_insync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '1;
      else        chain_q <= {chain_q[STAGES-2:0], d};
   end

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int HALF_CYCLES  = 40,
   parameter int SYNC_STAGES  = 2,
   parameter int PREAMBLE_LEN = 32,
   parameter int RECOVER_LEN  = 32,
   parameter int PHY_W        = 5,
   parameter int REG_W        = 5,
   parameter int DATA_W       = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              rd_i,
   input  logic [PHY_W-1:0]  phy_addr_i,
   input  logic [REG_W-1:0]  reg_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              mdc_o,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   input  logic              mdio_i
);
   // slot map derived from the field widths
   localparam int TA_POS   = PREAMBLE_LEN + 4 + PHY_W + REG_W;
   localparam int RD_END   = TA_POS + DATA_W + 1;
   localparam int WR_END   = TA_POS + DATA_W + 2;
   localparam int ER_END   = TA_POS + RECOVER_LEN;
   localparam int MAX_END  = (ER_END > WR_END) ? ER_END : WR_END;
   localparam int SLOT_W   = $clog2(MAX_END + 1);
   localparam int TX_W     = 6 + PHY_W + REG_W + DATA_W;

   localparam logic [SLOT_W-1:0] S_PRE   = SLOT_W'(PREAMBLE_LEN);
   localparam logic [SLOT_W-1:0] S_TA    = SLOT_W'(TA_POS);
   localparam logic [SLOT_W-1:0] S_RDLO  = SLOT_W'(TA_POS + 1);
   localparam logic [SLOT_W-1:0] S_RDHI  = SLOT_W'(TA_POS + DATA_W);
   localparam logic [SLOT_W-1:0] S_RDEND = SLOT_W'(RD_END);
   localparam logic [SLOT_W-1:0] S_WREND = SLOT_W'(WR_END);
   localparam logic [SLOT_W-1:0] S_EREND = SLOT_W'(ER_END);

   generate
      if (HALF_CYCLES < SYNC_STAGES + 1) begin : g_chk_half
         $error("mdio_master: HALF_CYCLES must exceed SYNC_STAGES");
      end
      if (PREAMBLE_LEN < 1 || RECOVER_LEN < 1 || DATA_W < 2) begin : g_chk_len
         $error("mdio_master: lengths out of range");
      end
   endgenerate

   logic              busy_q, mdc_q, o_q, oe_q, done_q, err_q, fail_q, rd_q;
   logic [SLOT_W-1:0] slot_q, last_q, nslot;
   logic [TX_W-1:0]   tx_q;
   logic [DATA_W-1:0] rx_q, rdata_q;
   logic              tick, din_s, take, n_oe, end_hi;

   mdio_halfgen #(.HALF_CYCLES(HALF_CYCLES)) u_half (
      .clk(clk), .rst_n(rst_n), .clr(take), .en(busy_q), .tick(tick)
   );

   mdio_insync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(mdio_i), .q(din_s)
   );

   assign take   = start_i && !busy_q;
   assign end_hi = tick && mdc_q;
   assign nslot  = busy_q ? slot_q + 1'b1 : '0;

   always_comb begin
      if (rd_q && busy_q) n_oe = (nslot < S_TA);
      else if (busy_q)    n_oe = (nslot < S_WREND);
      else                n_oe = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         mdc_q   <= 1'b1;
         o_q     <= 1'b1;
         oe_q    <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
         fail_q  <= 1'b0;
         rd_q    <= 1'b0;
         slot_q  <= '0;
         last_q  <= '0;
         tx_q    <= '0;
         rx_q    <= '0;
         rdata_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (take) begin
            busy_q <= 1'b1;
            mdc_q  <= 1'b0;
            o_q    <= 1'b1;
            oe_q   <= 1'b1;
            slot_q <= '0;
            rd_q   <= rd_i;
            fail_q <= 1'b0;
            last_q <= rd_i ? S_RDEND : S_WREND;
            tx_q   <= {START_PAT, rd_i ? OPC_READ : OPC_WRITE,
                       phy_addr_i, reg_addr_i, WR_TURN, wdata_i};
         end else if (tick && !mdc_q) begin
            mdc_q <= 1'b1;
         end else if (end_hi) begin
            if (rd_q && !fail_q && slot_q == S_TA && din_s) begin
               fail_q <= 1'b1;
               last_q <= S_EREND;
            end
            if (rd_q && slot_q >= S_RDLO && slot_q <= S_RDHI)
               rx_q <= {rx_q[DATA_W-2:0], din_s};
            if (slot_q == last_q) begin
               busy_q  <= 1'b0;
               done_q  <= 1'b1;
               oe_q    <= 1'b0;
               err_q   <= fail_q;
               rdata_q <= (rd_q && !fail_q) ? rx_q : '0;
            end else begin
               mdc_q  <= 1'b0;
               slot_q <= nslot;
               oe_q   <= n_oe;
               if (nslot >= S_PRE) begin
                  o_q  <= tx_q[TX_W-1];
                  tx_q <= {tx_q[TX_W-2:0], 1'b0};
               end
            end
         end
      end
   end

   assign busy_o    = busy_q;
   assign done_o    = done_q;
   assign err_o     = err_q;
   assign rdata_o   = rdata_q;
   assign mdc_o     = mdc_q;
   assign mdio_o    = o_q;
   assign mdio_oe_o = oe_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start_i,
   input logic              busy_o,
   input logic              done_o,
   input logic              err_o,
   input logic [DATA_W-1:0] rdata_o,
   input logic              mdc_o,
   input logic              mdio_o,
   input logic              mdio_oe_o
);
   p_idle_rest_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (mdc_o && !mdio_oe_o));

   p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   p_done_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   p_busy_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));

   p_line_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o) && mdc_o && $past(mdc_o))
         |-> ($stable(mdio_o) && $stable(mdio_oe_o)));

   p_err_nodata_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (rdata_o == '0));
endmodule

bind mdio_master mdio_master_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
   .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o), .mdc_o(mdc_o),
   .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o)
);

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
   localparam int HALF = 4;

   typedef struct packed {
      logic        rd;
      logic [4:0]  phy;
      logic [4:0]  rg;
      logic [15:0] data;
      logic        bad_ta;
   } item_t;

   logic clk = 0, rst_n = 0;
   logic start_i = 0, rd_i = 0;
   logic [4:0] phy_addr_i = 0, reg_addr_i = 0;
   logic [15:0] wdata_i = 0;
   logic busy_o, done_o, err_o, mdc_o, mdio_o, mdio_oe_o, mdio_i;
   logic [15:0] rdata_o;
   logic phy_bit = 1'b1;

   int checks = 0, errors = 0, dones = 0;
   bit finished = 0;
   item_t exp_q[$];

   always #2.5 clk = ~clk;

   assign mdio_i = mdio_oe_o ? mdio_o : phy_bit;

   mdio_master #(.HALF_CYCLES(HALF)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
      .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .rdata_o(rdata_o),
      .mdc_o(mdc_o), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic pulse_start(input item_t it);
      @(negedge clk);
      start_i = 1; rd_i = it.rd; phy_addr_i = it.phy;
      reg_addr_i = it.rg; wdata_i = it.data;
      @(negedge clk);
      start_i = 0;
   endtask

   task automatic xact(input item_t it);
      int d0;
      while (busy_o) @(negedge clk);
      exp_q.push_back(it);
      d0 = dones;
      pulse_start(it);
      while (dones == d0) @(negedge clk);
   endtask

   // monitor / scoreboard
   logic cap_o [0:127];
   logic cap_oe[0:127];
   int rise_cnt = 0, since = 0, ph_bad = 0, stab_bad = 0;
   bit have_edge = 0, want_low = 0;
   logic mdc_p = 1, o_p = 1, oe_p = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         since++;
         if (want_low) begin
            chk(done_o == 0, "R2 done lasts one cycle", done_o, 0);
            want_low = 0;
         end
         if (busy_o && mdc_o && mdc_p && (mdio_o != o_p || mdio_oe_o != oe_p))
            stab_bad++;
         if (mdc_o != mdc_p) begin
            if (have_edge && since != HALF) ph_bad++;
            have_edge = 1;
            since = 0;
            if (mdc_o) begin
               if (rise_cnt < 128) begin
                  cap_o[rise_cnt] = mdio_o;
                  cap_oe[rise_cnt] = mdio_oe_o;
               end
               rise_cnt++;
            end else begin
               phy_bit = 1'b1;
               if (exp_q.size() > 0 && exp_q[0].rd) begin
                  if (rise_cnt == 46) phy_bit = exp_q[0].bad_ta;
                  else if (rise_cnt >= 47 && rise_cnt <= 62)
                     phy_bit = exp_q[0].data[62 - rise_cnt];
               end
            end
         end
         if (done_o) begin
            item_t e;
            logic [4:0] gp, gr;
            logic [15:0] gd;
            bit ok;
            dones++;
            want_low = 1;
            chk(busy_o == 0, "R2 busy low with done", busy_o, 0);
            if (exp_q.size() == 0) begin
               chk(0, "R3 unexpected done", 1, 0);
            end else begin
               e = exp_q.pop_front();
               ok = 1;
               for (int i = 0; i < 32; i++) if (!cap_o[i] || !cap_oe[i]) ok = 0;
               chk(ok && cap_o[32] == 0 && cap_o[33] == 1 && cap_oe[32] && cap_oe[33],
                   "R4 preamble and start", {cap_o[32], cap_o[33]}, 2'b01);
               chk(cap_o[34] == e.rd && cap_o[35] == !e.rd,
                   "R5 opcode", {cap_o[34], cap_o[35]}, {e.rd, !e.rd});
               for (int i = 0; i < 5; i++) begin
                  gp[4 - i] = cap_o[36 + i];
                  gr[4 - i] = cap_o[41 + i];
               end
               chk(gp == e.phy && gr == e.rg, "R6 addresses",
                   {gp, gr}, {e.phy, e.rg});
               chk(ph_bad == 0 && stab_bad == 0, "R7 phase width and hold",
                   ph_bad + stab_bad, 0);
               if (e.rd && e.bad_ta) begin
                  ok = 1;
                  for (int i = 46; i < 79; i++) if (cap_oe[i]) ok = 0;
                  chk(rise_cnt == 79 && ok, "R10 recovery length", rise_cnt, 79);
                  chk(err_o == 1 && rdata_o == 0, "R10 error no data",
                      {err_o, rdata_o}, {1'b1, 16'h0});
               end else if (e.rd) begin
                  ok = 1;
                  for (int i = 46; i < 64; i++) if (cap_oe[i]) ok = 0;
                  chk(rise_cnt == 64 && ok, "R9 read length/release", rise_cnt, 64);
                  chk(err_o == 0 && rdata_o == e.data, "R9 read data",
                      {err_o, rdata_o}, {1'b0, e.data});
               end else begin
                  ok = 1;
                  for (int i = 0; i < 64; i++) if (!cap_oe[i]) ok = 0;
                  for (int i = 0; i < 16; i++) gd[15 - i] = cap_o[48 + i];
                  chk(rise_cnt == 65 && ok && !cap_oe[64], "R8 write length",
                      rise_cnt, 65);
                  chk(cap_o[46] == 1 && cap_o[47] == 0 && gd == e.data,
                      "R8 turnaround and data", {cap_o[46], cap_o[47], gd},
                      {2'b10, e.data});
               end
            end
            rise_cnt = 0; have_edge = 0; ph_bad = 0; stab_bad = 0;
         end
      end
      mdc_p = mdc_o; o_p = mdio_o; oe_p = mdio_oe_o;
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      int d0;
      item_t it;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(mdc_o == 1 && mdio_oe_o == 0 && busy_o == 0 && done_o == 0,
          "R1 reset state", {mdc_o, mdio_oe_o, busy_o, done_o}, 4'b1000);

      xact('{rd:0, phy:5'h01, rg:5'h00, data:16'hA5C3, bad_ta:0});
      xact('{rd:0, phy:5'h1F, rg:5'h1F, data:16'hFFFF, bad_ta:0});
      xact('{rd:1, phy:5'h10, rg:5'h01, data:16'h8001, bad_ta:0});
      xact('{rd:1, phy:5'h0A, rg:5'h15, data:16'h5555, bad_ta:0});
      xact('{rd:1, phy:5'h03, rg:5'h02, data:16'hBEEF, bad_ta:1});
      // a read right after the error frame must work normally
      xact('{rd:1, phy:5'h03, rg:5'h02, data:16'h0000, bad_ta:0});

      // R3: second request during a frame is dropped
      it = '{rd:0, phy:5'h12, rg:5'h09, data:16'h1234, bad_ta:0};
      exp_q.push_back(it);
      d0 = dones;
      pulse_start(it);
      repeat (100) @(negedge clk);
      pulse_start('{rd:1, phy:5'h07, rg:5'h07, data:16'hFFFF, bad_ta:0});
      while (dones == d0) @(negedge clk);
      repeat (40) @(negedge clk);
      chk(dones == d0 + 1 && busy_o == 0 && mdc_o == 1,
          "R3 busy request ignored", dones - d0, 1);
      chk(mdc_o == 1 && mdio_oe_o == 0, "R1 idle after frame",
          {mdc_o, mdio_oe_o}, 2'b10);

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule